// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 interrupt request lines and turns them into two processor requests: a fast request and a normal request. Each line can also be forced active from software. Each line has an enable mask and a route select, so it is sent either to the fast request or to the normal request. Sixteen programmable vector slots each bind one source line to a service address. Slot 0 has the highest priority and slot 15 the lowest. An enabled normal request that no slot claims is served through one shared default address.

Software talks to the block over a single-cycle synchronous register bus. The bus is always ready, and it has no back-pressure and no wait states. Write data is taken on the clock edge where the write strobe is high. Read data is combinational from the address. A read strobe on the vector register, sampled at the clock edge, starts a service. The block pushes the current priority level onto a 17-entry stack and masks requests of equal or lower priority. Any write to the vector register ends that service and pops the previous level.

Top module: `intc_vectored`

## Requirements
- R1: After reset, the enable, software and route-select registers read 0, both request outputs are low, and the vector register reads the default address, which is 0.
- R2: A write to enable-set (0x010) or software-set (0x018) ORs the written 1 bits into the register. A write to enable-clear (0x014) or software-clear (0x01C) clears those bits. 0 bits leave the register unchanged. Enable is read back at 0x010 and the software bits at 0x018.
- R3: Raw status (0x000) equals the hardware lines OR the software bits, for every line.
- R4: Normal status (0x004) is raw AND enable AND NOT select. A request forced from software is masked by the same enable bit as a hardware request.
- R5: Fast status (0x008) is raw AND enable AND select, where select is at 0x00C and bit value 1 means fast. fiq_o is high exactly when any fast status bit is set. It is not affected by the service level.
- R6: Slot n has its address at 0x100+4n and its control at 0x200+4n, with bit 5 as enable and bits 4:0 as the source line. The vector register (0x030) returns the address of the lowest-numbered enabled slot whose source has normal status set and whose number is below the current level.
- R7: When no slot qualifies, the vector register returns the default address (0x034). A slot whose enable bit is clear never qualifies.
- R8: A strobed read of 0x030 raises the level to that of the served slot, or to the default level if no slot qualified. Requests of equal or lower priority then stop driving irq_o, while a higher-priority slot still raises it.
- R9: A write of any value to 0x030 restores the level held before the most recent unfinished read. With no service open, the level is idle, and at idle every normal status bit can raise irq_o.
- R10: irq_o and fiq_o are registered. They change one clock after the input, register or level change that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 32 | Hardware request lines, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (acts only on 0x030) |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench covers four corner cases:
- A software-forced line whose enable is clear must stay silent. A design that bypasses the mask would raise irq_o.
- Nested service is exercised. A higher slot arrives while a lower one is being served, and two writes unwind the levels. A stack that pops the wrong entry leaves irq_o high or low at the wrong step.
- Slot priority and fallback are checked when a slot is disabled and when a request is routed to the default path. A wrong encoder returns the wrong address.
- The output timing is checked on the exact cycle. A design without the output register, or with an extra stage, shows the request one cycle early or one cycle late.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;
  localparam logic [11:0] OFF_RAW    = 12'h000;
  localparam logic [11:0] OFF_NSTAT  = 12'h004;
  localparam logic [11:0] OFF_FSTAT  = 12'h008;
  localparam logic [11:0] OFF_ROUTE  = 12'h00C;
  localparam logic [11:0] OFF_EN_SET = 12'h010;
  localparam logic [11:0] OFF_EN_CLR = 12'h014;
  localparam logic [11:0] OFF_SW_SET = 12'h018;
  localparam logic [11:0] OFF_SW_CLR = 12'h01C;
  localparam logic [11:0] OFF_VEC    = 12'h030;
  localparam logic [11:0] OFF_DEFV   = 12'h034;
  localparam logic [3:0]  PAGE_SADDR = 4'h1;
  localparam logic [3:0]  PAGE_SCTL  = 4'h2;
  localparam int          BUS_W      = 32;
endpackage

// File: rtl/intc_mask_regs.sv
module intc_mask_regs
  import intc_vec_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [11:0]        addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] src,
  output logic [NUM_SRC-1:0] raw,
  output logic [NUM_SRC-1:0] nstat,
  output logic [NUM_SRC-1:0] fstat,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] sw_q,
  output logic [NUM_SRC-1:0] route_q
);
  logic [NUM_SRC-1:0] wbits;
  assign wbits = wdata[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      sw_q    <= '0;
      route_q <= '0;
    end else if (wr) begin
      case (addr)
        OFF_EN_SET: en_q    <= en_q | wbits;
        OFF_EN_CLR: en_q    <= en_q & ~wbits;
        OFF_SW_SET: sw_q    <= sw_q | wbits;
        OFF_SW_CLR: sw_q    <= sw_q & ~wbits;
        OFF_ROUTE:  route_q <= wbits;
        default: ;
      endcase
    end
  end

  assign raw   = src | sw_q;
  assign nstat = raw & en_q & ~route_q;
  assign fstat = raw & en_q & route_q;

  // R2
  en_set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R2
  en_clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_EN_CLR) |=> ((en_q & $past(wbits)) == '0));
endmodule

// File: rtl/intc_vec_table.sv
module intc_vec_table
  import intc_vec_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int LVL_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [11:0]                 addr,
  input  logic [BUS_W-1:0]            wdata,
  input  logic [NUM_SRC-1:0]          nstat,
  input  logic [LVL_W-1:0]            cur_lvl,
  output logic                        hit,
  output logic [$clog2(NUM_SLOT)-1:0] hit_idx,
  output logic [BUS_W-1:0]            vec_addr,
  output logic [BUS_W-1:0]            tbl_rdata,
  output logic                        tbl_rsel
);
  localparam int IDX_W = $clog2(NUM_SLOT);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [BUS_W-1:0] slot_addr [NUM_SLOT];
  logic [SRC_W-1:0] slot_src  [NUM_SLOT];
  logic             slot_en   [NUM_SLOT];
  logic [BUS_W-1:0] def_vec;
  logic [NUM_SLOT-1:0] slot_act;

  logic [5:0]       widx;
  logic             widx_ok;
  logic [IDX_W-1:0] sidx;
  assign widx    = addr[7:2];
  assign widx_ok = (widx < 6'(NUM_SLOT)) && (addr[1:0] == 2'b00);
  assign sidx    = widx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      def_vec <= '0;
      for (int k = 0; k < NUM_SLOT; k++) begin
        slot_addr[k] <= '0;
        slot_src[k]  <= '0;
        slot_en[k]   <= 1'b0;
      end
    end else if (wr) begin
      if (addr == OFF_DEFV) def_vec <= wdata;
      if (addr[11:8] == PAGE_SADDR && widx_ok) slot_addr[sidx] <= wdata;
      if (addr[11:8] == PAGE_SCTL && widx_ok) begin
        slot_en[sidx]  <= wdata[5];
        slot_src[sidx] <= wdata[SRC_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    assign slot_act[g] = slot_en[g] && nstat[slot_src[g]] && (LVL_W'(g) < cur_lvl);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (slot_act[k]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
    end
  end

  assign vec_addr = hit ? slot_addr[hit_idx] : def_vec;

  always_comb begin
    tbl_rsel  = 1'b1;
    tbl_rdata = '0;
    if (addr == OFF_DEFV) tbl_rdata = def_vec;
    else if (addr[11:8] == PAGE_SADDR && widx_ok) tbl_rdata = slot_addr[sidx];
    else if (addr[11:8] == PAGE_SCTL && widx_ok)
      tbl_rdata = BUS_W'({slot_en[sidx], SRC_W'(slot_src[sidx])}) | (slot_en[sidx] ? 32'h20 : 32'h0);
    else tbl_rsel = 1'b0;
  end

  // R8
  hit_above_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (LVL_W'(hit_idx) < cur_lvl));
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack #(
  parameter int NUM_SLOT = 16,
  parameter int LVL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] cur_lvl
);
  localparam int DEPTH = NUM_SLOT + 1;
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SLOT + 1);

  logic [LVL_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]  sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= '0;
      cur_lvl <= IDLE;
      for (int k = 0; k < DEPTH; k++) stk[k] <= IDLE;
    end else if (push && sp < SP_W'(DEPTH)) begin
      stk[sp] <= cur_lvl;
      sp      <= sp + 1'b1;
      cur_lvl <= new_lvl;
    end else if (pop && sp != '0) begin
      sp      <= sp - 1'b1;
      cur_lvl <= stk[sp - 1'b1];
    end
  end

  // R8
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && sp < SP_W'(DEPTH)) |=> (sp == $past(sp) + 1'b1 && cur_lvl == $past(new_lvl)));
  // R9
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && pop && sp != '0) |=> (sp == $past(sp) - 1'b1));
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_vec_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int LVL_W = $clog2(NUM_SLOT + 2);
  localparam int IDX_W = $clog2(NUM_SLOT);
  localparam logic [LVL_W-1:0] DEF_LVL = LVL_W'(NUM_SLOT);
  localparam logic [LVL_W-1:0] IDLE    = LVL_W'(NUM_SLOT + 1);

  logic [NUM_SRC-1:0] raw, nstat, fstat, en_q, sw_q, route_q;
  logic               hit, tbl_rsel, push, pop;
  logic [IDX_W-1:0]   hit_idx;
  logic [BUS_W-1:0]   vec_addr, tbl_rdata;
  logic [LVL_W-1:0]   cur_lvl, new_lvl;
  logic               irq_d, fiq_d;

  intc_mask_regs #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .src(irq_src_i), .raw(raw), .nstat(nstat), .fstat(fstat),
    .en_q(en_q), .sw_q(sw_q), .route_q(route_q));

  intc_vec_table #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .LVL_W(LVL_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .nstat(nstat), .cur_lvl(cur_lvl), .hit(hit), .hit_idx(hit_idx),
    .vec_addr(vec_addr), .tbl_rdata(tbl_rdata), .tbl_rsel(tbl_rsel));

  assign push    = bus_rd_i && bus_addr_i == OFF_VEC;
  assign pop     = bus_wr_i && bus_addr_i == OFF_VEC;
  assign new_lvl = hit ? LVL_W'(hit_idx) : DEF_LVL;

  intc_lvl_stack #(.NUM_SLOT(NUM_SLOT), .LVL_W(LVL_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .new_lvl(new_lvl), .cur_lvl(cur_lvl));

  assign irq_d = hit || (cur_lvl == IDLE && |nstat);
  assign fiq_d = |fstat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  always_comb begin
    case (bus_addr_i)
      OFF_RAW:    bus_rdata_o = BUS_W'(raw);
      OFF_NSTAT:  bus_rdata_o = BUS_W'(nstat);
      OFF_FSTAT:  bus_rdata_o = BUS_W'(fstat);
      OFF_ROUTE:  bus_rdata_o = BUS_W'(route_q);
      OFF_EN_SET: bus_rdata_o = BUS_W'(en_q);
      OFF_SW_SET: bus_rdata_o = BUS_W'(sw_q);
      OFF_VEC:    bus_rdata_o = vec_addr;
      default:    bus_rdata_o = tbl_rsel ? tbl_rdata : '0;
    endcase
  end

  // R5
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fstat) |=> fiq_o);
  // R10
  irq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_o);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|nstat)) |=> !irq_o);
endmodule

// File: tb/intc_vectored_test.sv
module intc_vectored_test;
  import intc_vec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_o, fiq_o;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  intc_vectored uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  // {hw, soft, enable, route, exp_irq, exp_fiq}
  localparam int NV = 7;
  localparam logic [129:0] VTAB [NV] = '{
    {32'h0000_0001, 32'h0, 32'h0000_0001, 32'h0, 1'b1, 1'b0},
    {32'h0000_0001, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0},
    {32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1, 1'b0},
    {32'h0, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b0},
    {32'h0000_0010, 32'h0, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b1},
    {32'h0000_0030, 32'h0, 32'h0000_0030, 32'h0000_0010, 1'b1, 1'b1},
    {32'h0000_F0F0, 32'h0000_0F00, 32'h0000_0100, 32'h0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #2 d = bus_rdata;
  endtask

  task automatic br_vec(output logic [31:0] d);
    @(negedge clk); bus_addr = OFF_VEC; bus_rd = 1'b1; #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    peek(OFF_EN_SET, rv); chk("R1 enable", rv, 0);
    peek(OFF_SW_SET, rv); chk("R1 soft", rv, 0);
    peek(OFF_ROUTE, rv);  chk("R1 route", rv, 0);
    peek(OFF_VEC, rv);    chk("R1 vector", rv, 0);

    // R2 set/clear semantics
    bw(OFF_EN_SET, 32'h5); bw(OFF_EN_SET, 32'h2);
    peek(OFF_EN_SET, rv); chk("R2 set or", rv, 32'h7);
    bw(OFF_EN_CLR, 32'h4);
    peek(OFF_EN_SET, rv); chk("R2 clear", rv, 32'h3);
    bw(OFF_EN_CLR, 32'h0);
    peek(OFF_EN_SET, rv); chk("R2 zero bits", rv, 32'h3);
    bw(OFF_SW_SET, 32'h9); bw(OFF_SW_CLR, 32'h1);
    peek(OFF_SW_SET, rv); chk("R2 soft", rv, 32'h8);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] hw, sw, en, sel;
      {hw, sw, en, sel} = VTAB[i][129:2];
      bw(OFF_EN_CLR, '1); bw(OFF_SW_CLR, '1);
      bw(OFF_EN_SET, en); bw(OFF_ROUTE, sel); bw(OFF_SW_SET, sw);
      irq_src = hw;
      settle();
      chk("R4 irq_o", 32'(irq_o), 32'(VTAB[i][1]));
      chk("R5 fiq_o", 32'(fiq_o), 32'(VTAB[i][0]));
      peek(OFF_RAW, rv);   chk("R3 raw", rv, hw | sw);
      peek(OFF_NSTAT, rv); chk("R4 normal status", rv, (hw | sw) & en & ~sel);
      peek(OFF_FSTAT, rv); chk("R5 fast status", rv, (hw | sw) & en & sel);
    end

    bw(OFF_EN_CLR, '1); bw(OFF_SW_CLR, '1); bw(OFF_ROUTE, 0);
    irq_src = '0;
    bw(12'h100, 32'hA000); bw(12'h200, 32'h23);
    bw(12'h104, 32'hB000); bw(12'h204, 32'h25);
    bw(OFF_DEFV, 32'hD000);
    bw(OFF_EN_SET, 32'hA8);
    irq_src = 32'hA0;
    settle();
    chk("R9 idle irq", 32'(irq_o), 1);
    peek(OFF_VEC, rv); chk("R6 slot1 address", rv, 32'hB000);
    irq_src = 32'hA8;
    peek(OFF_VEC, rv); chk("R6 slot0 wins", rv, 32'hA000);
    irq_src = 32'h80;
    peek(OFF_VEC, rv); chk("R7 default", rv, 32'hD000);

    irq_src = 32'hA0;
    settle();
    br_vec(rv); chk("R6 served slot1", rv, 32'hB000);
    settle();
    chk("R8 masked equal/lower", 32'(irq_o), 0);
    peek(OFF_VEC, rv); chk("R8 no slot qualifies", rv, 32'hD000);
    irq_src = 32'hA8;
    settle();
    chk("R8 higher preempts", 32'(irq_o), 1);
    br_vec(rv); chk("R8 served slot0", rv, 32'hA000);
    settle();
    chk("R8 nested masked", 32'(irq_o), 0);
    bw(OFF_VEC, 32'h0);
    settle();
    chk("R9 restore level1", 32'(irq_o), 1);
    irq_src = 32'hA0;
    settle();
    chk("R9 level1 masks slot1", 32'(irq_o), 0);
    bw(OFF_VEC, 32'h1234);
    settle();
    chk("R9 back to idle", 32'(irq_o), 1);
    peek(OFF_VEC, rv); chk("R9 vector after unwind", rv, 32'hB000);

    bw(12'h204, 32'h05);
    peek(OFF_VEC, rv); chk("R7 disabled slot", rv, 32'hD000);

    irq_src = '0;
    settle();
    chk("R10 quiet", 32'(irq_o), 0);
    @(negedge clk); irq_src = 32'h80; #1;
    chk("R10 not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R10 one clock later", 32'(irq_o), 1);

    bw(OFF_ROUTE, 32'h80);
    br_vec(rv);
    @(negedge clk);
    chk("R5 fiq ignores level", 32'(fiq_o), 1);
    chk("R5 routed off irq", 32'(irq_o), 0);

    summary();
  end
endmodule